// File: doc/BRIEF.md
# Priority-Value Shared Bus Arbiter

This block lets several requesters share one write-only bus port. Each requester raises a valid line together with a nonzero numeric priority. The arbiter keeps an effective priority per requester and picks the largest one. It then publishes that winning value on a grant bus that every requester can see. A requester knows it has won when the grant equals its own value.

After a one-cycle settle interval the arbiter captures the winner's 8-bit address and 8-bit data. It drives them onto the bus with an enable for five cycles. It then clears the grant to zero, pulses the winner's done line and waits out a five-cycle gap before it arbitrates again. An optional aging mode, chosen by a parameter, adds a fixed step to every waiting loser each time the grant changes value, so that a requester with a low value is not starved. Two live requesters holding the same value is illegal. When that happens a sticky error flag is raised and the lower-index requester wins.

The control is a four-state machine:
- IDLE: waits for a nonzero resolved priority. The transition IDLE→SETTLE issues the grant.
- SETTLE: lasts one cycle. SETTLE→DRIVE captures the operands and raises the enable.
- DRIVE: lasts five cycles. DRIVE→GAP clears the grant, drops the enable and pulses done.
- GAP: lasts five cycles. GAP→IDLE re-opens arbitration.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, grant is 0, bus_oe is 0, bus_addr and bus_data are 0, done is all zero and dup_err is 0.
- R2: A requester's priority is loaded one cycle after its req_valid is first seen. In IDLE the arbiter grants on the next edge, putting the largest live effective priority on grant. A priority value of 0, or req_valid low, counts as no request and never produces a grant.
- R3: bus_oe rises exactly one cycle after grant becomes nonzero, and it is never high while grant is 0.
- R4: bus_oe stays high for exactly 5 cycles. During that time bus_addr and bus_data hold the winner's address and data as captured at the start of the drive. Outside the drive, both are 0.
- R5: On the edge where bus_oe falls, grant returns to 0 and the winner's done bit pulses for one cycle.
- R6: Between the end of one grant and the next one, grant stays 0 for at least 6 cycles (5 gap cycles plus 1 idle cycle).
- R7: With aging off, suppose requesters with priorities 1 and 2 request together and priority 3 requests 3 cycles later. The order of service is then 2, 3, 1.
- R8: With AGE_EN=1, every live requester that is not the current winner and whose value differs from the new grant adds AGE_STEP (10) to its effective priority on each edge where grant changes value. The sum saturates at 2^W-1. With AGE_EN=0 the priorities never change.
- R9: If two live requesters hold the same nonzero effective priority, dup_err is set and stays set until reset. The lower-index one of them wins.
- R10: done is at most one-hot, and its set bit is the index of the requester that was just served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-requester request line |
| req_prio | input | N*W | Per-requester base priority, slot i at bits i*W+:W |
| req_addr | input | N*ADDR_W | Per-requester write address |
| req_data | input | N*DATA_W | Per-requester write data |
| grant | output | W | Winning priority value, 0 when no cycle is in progress |
| done | output | N | One-cycle pulse to the served requester |
| bus_oe | output | 1 | Bus drive enable |
| bus_addr | output | ADDR_W | Bus address, 0 when not driven |
| bus_data | output | DATA_W | Bus data, 0 when not driven |
| dup_err | output | 1 | Sticky duplicate-priority flag |

## Verification
Each result has a fixed due time, counted from the input that causes it:
- A request's priority is loaded on the first edge after req_valid rises, and a grant can appear on the edge after that.
- bus_oe follows the grant by exactly one cycle and stays high for five cycles.
- grant clears and done pulses on the edge where bus_oe falls.
- No new grant can appear until six zero-grant cycles have passed.

A behavioural model is stepped on each rising edge, and its outputs are compared with the design's on the following falling edge, so every due cycle is checked exactly where it lands. Monitors also measure the settle, drive and gap distances directly, and they record the order of service and the grant values for the fixed scenarios.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DRIVE  = 2'd2,
        ST_GAP    = 2'd3
    } pba_state_e;

endpackage

// File: rtl/pba_slot.sv
module pba_slot #(
    parameter int W        = 8,
    parameter int AGE_EN   = 0,
    parameter int AGE_STEP = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] base_prio,
    input  logic         grant_chg,
    input  logic [W-1:0] grant_nxt,
    input  logic         held,
    output logic [W-1:0] eff
);
    localparam logic [W:0] MAXV   = {1'b0, {W{1'b1}}};
    localparam logic [W:0] STEP_V = (W+1)'(AGE_STEP);

    logic         act_q;
    logic [W-1:0] eff_q;
    logic [W:0]   sum;
    logic [W-1:0] aged;
    logic         age_hit;

    always_comb begin
        sum  = {1'b0, eff_q} + STEP_V;
        aged = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
    end

    assign age_hit = (AGE_EN != 0) && grant_chg && !held &&
                     (eff_q != '0) && (eff_q != grant_nxt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            eff_q <= '0;
        end else if (!req_valid) begin
            act_q <= 1'b0;
            eff_q <= '0;
        end else if (!act_q) begin
            act_q <= 1'b1;
            eff_q <= base_prio;
        end else if (age_hit) begin
            eff_q <= aged;
        end
    end

    assign eff = eff_q;

    // R8: a held request never loses value (saturation, no wrap)
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && req_valid) |=> (eff_q >= $past(eff_q)));

    // R8: without aging a held request keeps its value
    p_no_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (AGE_EN == 0 && act_q && req_valid) |=> $stable(eff_q));

endmodule

// File: rtl/pba_resolve.sv
module pba_resolve #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] eff_flat,
    output logic [W-1:0]   best,
    output logic [N-1:0]   best_hot,
    output logic           dup_err
);
    logic dup_now;
    logic dup_q;

    always_comb begin
        best     = '0;
        best_hot = '0;
        for (int i = 0; i < N; i++) begin
            if (eff_flat[i*W +: W] > best) begin
                best     = eff_flat[i*W +: W];
                best_hot = '0;
                best_hot[i] = 1'b1;
            end
        end
    end

    always_comb begin
        dup_now = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if ((eff_flat[i*W +: W] != '0) &&
                    (eff_flat[i*W +: W] == eff_flat[j*W +: W]))
                    dup_now = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dup_q <= 1'b0;
        else        dup_q <= dup_q | dup_now;
    end

    assign dup_err = dup_q;

    // R9: flag is sticky
    p_dup_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dup_q) |-> dup_q);

    // R2: a nonzero winner always names exactly one requester
    p_best_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (best != '0) |-> ($countones(best_hot) == 1));

    p_best_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (best == '0) |-> (best_hot == '0));

endmodule

// File: rtl/pba_fsm.sv
module pba_fsm
    import pba_pkg::*;
#(
    parameter int N      = 4,
    parameter int W      = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETTLE = 1,
    parameter int DRIVE  = 5,
    parameter int GAP    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        best,
    input  logic [N-1:0]        best_hot,
    input  logic [N*ADDR_W-1:0] req_addr,
    input  logic [N*DATA_W-1:0] req_data,
    output logic [W-1:0]        grant,
    output logic [W-1:0]        grant_nxt,
    output logic                grant_chg,
    output logic [N-1:0]        held_mask,
    output logic                bus_oe,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic [N-1:0]        done
);
    localparam int CMAX = (SETTLE > DRIVE) ? ((SETTLE > GAP) ? SETTLE : GAP)
                                           : ((DRIVE > GAP) ? DRIVE : GAP);
    localparam int CW   = $clog2(CMAX + 1);
    localparam int ZMAX = GAP + 1;
    localparam int ZW   = $clog2(ZMAX + 1);
    localparam int OMAX = DRIVE + 1;
    localparam int OW   = $clog2(OMAX + 1);

    pba_state_e        st_q, st_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [W-1:0]      grant_q;
    logic [N-1:0]      win_q;
    logic              oe_q;
    logic [ADDR_W-1:0] addr_q, sel_addr;
    logic [DATA_W-1:0] data_q, sel_data;
    logic [N-1:0]      done_q;
    logic              take_grant, start_drive, end_drive;

    // next-state logic
    always_comb begin
        st_n        = st_q;
        cnt_n       = cnt_q + 1'b1;
        take_grant  = 1'b0;
        start_drive = 1'b0;
        end_drive   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                cnt_n = '0;
                if (best != '0) begin
                    st_n       = ST_SETTLE;
                    take_grant = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == CW'(SETTLE - 1)) begin
                    st_n        = ST_DRIVE;
                    cnt_n       = '0;
                    start_drive = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (cnt_q == CW'(DRIVE - 1)) begin
                    st_n      = ST_GAP;
                    cnt_n     = '0;
                    end_drive = 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_q == CW'(GAP - 1)) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        grant_nxt = take_grant ? best : (end_drive ? '0 : grant_q);
        grant_chg = take_grant || end_drive;
        held_mask = take_grant ? best_hot : win_q;
    end

    always_comb begin
        sel_addr = '0;
        sel_data = '0;
        for (int i = 0; i < N; i++) begin
            if (win_q[i]) begin
                sel_addr = sel_addr | req_addr[i*ADDR_W +: ADDR_W];
                sel_data = sel_data | req_data[i*DATA_W +: DATA_W];
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            win_q   <= '0;
            oe_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= '0;
        end else begin
            grant_q <= grant_nxt;
            done_q  <= '0;
            if (take_grant) win_q <= best_hot;
            if (start_drive) begin
                oe_q   <= 1'b1;
                addr_q <= sel_addr;
                data_q <= sel_data;
            end
            if (end_drive) begin
                oe_q   <= 1'b0;
                addr_q <= '0;
                data_q <= '0;
                done_q <= win_q;
            end
        end
    end

    assign grant    = grant_q;
    assign bus_oe   = oe_q;
    assign bus_addr = addr_q;
    assign bus_data = data_q;
    assign done     = done_q;

    // checker counters
    logic [ZW-1:0] zrun_q;
    logic [OW-1:0] orun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun_q <= ZW'(ZMAX);
            orun_q <= '0;
        end else begin
            if (grant_q != '0)           zrun_q <= '0;
            else if (zrun_q != ZW'(ZMAX)) zrun_q <= zrun_q + 1'b1;
            if (!oe_q)                    orun_q <= '0;
            else if (orun_q != OW'(OMAX)) orun_q <= orun_q + 1'b1;
        end
    end

    p_oe_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (grant_q != '0));

    p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_q != '0) |-> !oe_q);

    p_oe_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> ($past(grant_q) != '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && $past(oe_q)) |-> ($stable(addr_q) && $stable(data_q) && $stable(grant_q)));

    p_oe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (orun_q < OW'(DRIVE)));

    p_done_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != '0) |-> (grant_q == '0 && $past(grant_q) != '0 && !oe_q && $past(oe_q)));

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_q != '0) |-> (zrun_q >= ZW'(GAP + 1)));

    p_done_hot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_q));

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
    parameter int N        = 4,
    parameter int W        = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int AGE_EN   = 0,
    parameter int AGE_STEP = 10,
    parameter int SETTLE   = 1,
    parameter int DRIVE    = 5,
    parameter int GAP      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_valid,
    input  logic [N*W-1:0]      req_prio,
    input  logic [N*ADDR_W-1:0] req_addr,
    input  logic [N*DATA_W-1:0] req_data,
    output logic [W-1:0]        grant,
    output logic [N-1:0]        done,
    output logic                bus_oe,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic                dup_err
);
    logic [N*W-1:0] eff_flat;
    logic [W-1:0]   best;
    logic [N-1:0]   best_hot;
    logic [W-1:0]   grant_nxt;
    logic           grant_chg;
    logic [N-1:0]   held_mask;

    for (genvar g = 0; g < N; g++) begin : g_slot
        pba_slot #(
            .W        (W),
            .AGE_EN   (AGE_EN),
            .AGE_STEP (AGE_STEP)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[g]),
            .base_prio (req_prio[g*W +: W]),
            .grant_chg (grant_chg),
            .grant_nxt (grant_nxt),
            .held      (held_mask[g]),
            .eff       (eff_flat[g*W +: W])
        );
    end

    pba_resolve #(.N(N), .W(W)) u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .eff_flat (eff_flat),
        .best     (best),
        .best_hot (best_hot),
        .dup_err  (dup_err)
    );

    pba_fsm #(
        .N      (N),
        .W      (W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SETTLE (SETTLE),
        .DRIVE  (DRIVE),
        .GAP    (GAP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .best      (best),
        .best_hot  (best_hot),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .grant     (grant),
        .grant_nxt (grant_nxt),
        .grant_chg (grant_chg),
        .held_mask (held_mask),
        .bus_oe    (bus_oe),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .done      (done)
    );

endmodule

// File: tb/prio_bus_arbiter_bench.sv
module pba_ref #(
    parameter int N   = 4,
    parameter int W   = 8,
    parameter int AGE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   vld,
    input  logic [N*W-1:0] prio,
    input  logic [N*8-1:0] addr,
    input  logic [N*8-1:0] data,
    output logic [W-1:0]   e_grant,
    output logic           e_oe,
    output logic [7:0]     e_addr,
    output logic [7:0]     e_data,
    output logic [N-1:0]   e_done,
    output logic           e_err
);
    int  eff [N];
    bit  act [N];
    int  phase, cnt, win;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin eff[i] = 0; act[i] = 0; end
            phase = 0; cnt = 0; win = 0;
            e_grant = 0; e_oe = 0; e_addr = 0; e_data = 0; e_done = 0; e_err = 0;
        end else begin
            int best, bi, ng, excl;
            bit dup;
            best = 0; bi = 0; dup = 0; excl = -1;
            for (int i = 0; i < N; i++)
                if (eff[i] > best) begin best = eff[i]; bi = i; end
            for (int i = 0; i < N; i++)
                for (int j = i + 1; j < N; j++)
                    if (eff[i] != 0 && eff[i] == eff[j]) dup = 1;
            if (dup) e_err = 1;
            ng = int'(e_grant);
            e_done = 0;
            case (phase)
                0: if (best > 0) begin ng = best; win = bi; excl = bi; phase = 1; cnt = 0; end
                1: if (cnt == 0) begin
                       phase = 2; cnt = 0; e_oe = 1;
                       e_addr = addr[win*8 +: 8]; e_data = data[win*8 +: 8];
                   end else cnt++;
                2: if (cnt == 4) begin
                       phase = 3; cnt = 0; e_oe = 0; e_addr = 0; e_data = 0;
                       ng = 0; e_done[win] = 1'b1; excl = win;
                   end else cnt++;
                default: if (cnt == 4) begin phase = 0; cnt = 0; end else cnt++;
            endcase
            for (int i = 0; i < N; i++) begin
                if (!vld[i]) begin act[i] = 0; eff[i] = 0; end
                else if (!act[i]) begin act[i] = 1; eff[i] = int'(prio[i*W +: W]); end
                else if (AGE != 0 && ng != int'(e_grant) && eff[i] != 0 &&
                         i != excl && eff[i] != ng) begin
                    eff[i] = eff[i] + 10;
                    if (eff[i] > (1 << W) - 1) eff[i] = (1 << W) - 1;
                end
            end
            e_grant = W'(ng);
        end
    end
endmodule

module prio_bus_arbiter_bench;
    localparam int N = 4;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   vld_a = '0, vld_b = '0;
    logic [N*W-1:0] prio = '0;
    logic [N*8-1:0] addr = '0, data = '0;

    logic [W-1:0] grant_a, grant_b, eg_a, eg_b;
    logic [N-1:0] done_a, done_b, ed_a, ed_b;
    logic         oe_a, oe_b, eo_a, eo_b, err_a, err_b, ee_a, ee_b;
    logic [7:0]   ba_a, bd_a, ba_b, bd_b, ea_a, edt_a, ea_b, edt_b;

    always #5 clk = ~clk;

    prio_bus_arbiter #(.N(N), .W(W), .AGE_EN(0)) u_prio_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_a), .req_prio(prio),
        .req_addr(addr), .req_data(data), .grant(grant_a), .done(done_a),
        .bus_oe(oe_a), .bus_addr(ba_a), .bus_data(bd_a), .dup_err(err_a));

    prio_bus_arbiter #(.N(N), .W(W), .AGE_EN(1)) u_prio_bus_arbiter_age (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_b), .req_prio(prio),
        .req_addr(addr), .req_data(data), .grant(grant_b), .done(done_b),
        .bus_oe(oe_b), .bus_addr(ba_b), .bus_data(bd_b), .dup_err(err_b));

    pba_ref #(.N(N), .W(W), .AGE(0)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .vld(vld_a), .prio(prio), .addr(addr), .data(data),
        .e_grant(eg_a), .e_oe(eo_a), .e_addr(ea_a), .e_data(edt_a), .e_done(ed_a), .e_err(ee_a));

    pba_ref #(.N(N), .W(W), .AGE(1)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .vld(vld_b), .prio(prio), .addr(addr), .data(data),
        .e_grant(eg_b), .e_oe(eo_b), .e_addr(ea_b), .e_data(edt_b), .e_done(ed_b), .e_err(ee_b));

    int checks = 0, fails = 0, cyc = 0;
    int ord_a[$], ord_b[$], gv_a[$], gv_b[$];
    logic [W-1:0] pg_a = '0, pg_b = '0;
    logic         poe_a = 1'b0;
    int rise_cyc = 0, oe_run = 0, zrun = 1000;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int hot_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic cmp_inst(input string tag, input logic [W-1:0] g, input logic [W-1:0] eg,
                            input logic o, input logic eo, input logic [7:0] a, input logic [7:0] ea,
                            input logic [7:0] d, input logic [7:0] ed, input logic [N-1:0] dn,
                            input logic [N-1:0] edn, input logic e, input logic ee);
        check(g == eg,   "R2",  {tag, " grant"},    int'(g),  int'(eg));
        check(o == eo,   "R4",  {tag, " bus_oe"},   int'(o),  int'(eo));
        check(a == ea,   "R4",  {tag, " bus_addr"}, int'(a),  int'(ea));
        check(d == ed,   "R4",  {tag, " bus_data"}, int'(d),  int'(ed));
        check(dn == edn, "R10", {tag, " done"},     int'(dn), int'(edn));
        check(e == ee,   "R9",  {tag, " dup_err"},  int'(e),  int'(ee));
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        cmp_inst("plain", grant_a, eg_a, oe_a, eo_a, ba_a, ea_a, bd_a, edt_a, done_a, ed_a, err_a, ee_a);
        cmp_inst("aged",  grant_b, eg_b, oe_b, eo_b, ba_b, ea_b, bd_b, edt_b, done_b, ed_b, err_b, ee_b);
        if (rst_n) begin
            if (grant_a != '0 && pg_a == '0) begin
                gv_a.push_back(int'(grant_a));
                rise_cyc = cyc;
                if (zrun < 1000) check(zrun >= 6, "R6", "zero-grant cycles before grant", zrun, 6);
            end
            if (grant_a == '0) begin if (zrun < 1000) zrun++; end
            else zrun = 0;
            if (oe_a && !poe_a) check(cyc - rise_cyc == 1, "R3", "grant to oe distance", cyc - rise_cyc, 1);
            if (oe_a) oe_run++;
            else if (poe_a) begin
                check(oe_run == 5, "R4", "oe length", oe_run, 5);
                oe_run = 0;
            end
            if (done_a != '0) begin
                ord_a.push_back(hot_idx(done_a));
                check(grant_a == '0 && pg_a != '0, "R5", "grant cleared at done", int'(grant_a), 0);
                check(!oe_a && poe_a, "R5", "oe falls at done", int'(oe_a), 0);
                vld_a = vld_a & ~done_a;
            end
            if (grant_b != '0 && pg_b == '0) gv_b.push_back(int'(grant_b));
            if (done_b != '0) begin
                ord_b.push_back(hot_idx(done_b));
                vld_b = vld_b & ~done_b;
            end
        end
        pg_a = grant_a; pg_b = grant_b; poe_a = oe_a;
    endtask

    task automatic set_req(input int i, input int p, input int a);
        prio[i*W +: W] = W'(p);
        addr[i*8 +: 8] = 8'(a);
        data[i*8 +: 8] = 8'(a) ^ 8'h5A;
        vld_a[i] = 1'b1;
        vld_b[i] = 1'b1;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int k = 0; k < 400 && q < 8; k++) begin
            tick();
            if (vld_a == '0 && vld_b == '0 && grant_a == '0 && grant_b == '0) q++;
            else q = 0;
        end
        check(q >= 8, "R5", "all requests served", q, 8);
    endtask

    task automatic check_q(input string req, input string what, input int got[$], input int exp[$]);
        check(got.size() == exp.size(), req, {what, " count"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] == exp[i], req, what, got[i], exp[i]);
    endtask

    task automatic clear_logs();
        ord_a.delete(); ord_b.delete(); gv_a.delete(); gv_b.delete();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(grant_a == '0 && grant_b == '0, "R1", "grant after reset", int'(grant_a), 0);
        check(!oe_a && !oe_b, "R1", "oe after reset", int'(oe_a), 0);
        check(ba_a == '0 && bd_a == '0, "R1", "bus after reset", int'(ba_a), 0);
        check(done_a == '0 && done_b == '0, "R1", "done after reset", int'(done_a), 0);
        check(!err_a && !err_b, "R1", "dup_err after reset", int'(err_a), 0);

        // R2 zero priority is no request
        set_req(0, 0, 8'h0F);
        repeat (20) tick();
        check(gv_a.size() == 0 && gv_b.size() == 0, "R2", "grants from zero priority", gv_a.size(), 0);
        vld_a = '0; vld_b = '0;
        repeat (4) tick();

        // R7 / R8 ordering scenario
        clear_logs();
        set_req(0, 1, 8'h11);
        set_req(1, 2, 8'h22);
        repeat (3) tick();
        set_req(2, 3, 8'h33);
        wait_quiet();
        check_q("R7", "plain service order", ord_a, '{1, 2, 0});
        check_q("R2", "plain grant values", gv_a, '{2, 3, 1});
        check_q("R8", "aged service order", ord_b, '{1, 0, 2});
        check_q("R8", "aged grant values", gv_b, '{2, 21, 33});

        // R8 saturation
        clear_logs();
        set_req(0, 250, 8'hA0);
        set_req(1, 251, 8'hA1);
        wait_quiet();
        check_q("R2", "plain saturation grants", gv_a, '{251, 250});
        check_q("R8", "aged saturation grants", gv_b, '{251, 255});
        check(!err_a && !err_b, "R9", "no duplicate flag yet", int'(err_a), 0);

        // R9 duplicates
        clear_logs();
        set_req(1, 7, 8'hB1);
        set_req(3, 7, 8'hB3);
        wait_quiet();
        check_q("R9", "duplicate service order", ord_a, '{1, 3});
        check_q("R9", "aged duplicate grants", gv_b, '{7, 17});
        check(err_a && err_b, "R9", "dup_err sticky after drop", int'(err_a), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule